// File: doc/BRIEF.md
# CPU Differential Clock Stop Controller

This block decides, cycle by cycle, what each of a set of differential CPU clock pairs should be doing while the system asks for a clock stop or a full power-down. It takes two active-low request pins (stop and power-down), a per-pair free-run bit, a per-pair enable bit and two three-state mode bits. For every pair it gives a 3-bit drive code that tells an external current-mode buffer how to behave, and it gives the gated true and complement logic levels for that pair.

The block is clocked once per half period of the CPU clock it controls. An internal phase bit stands for the true clock level of a running pair, so a falling edge of the true clock, which is also a rising edge of the complement, is the clock edge where the phase bit goes from 1 to 0. Both requests pass through a synchronizer. They count only once they have been seen low on two consecutive falling-edge samples. A pair changes state only on such an edge, so an output never shows a short or stretched pulse.

Top module: `cpu_clk_stop_ctrl`

## Requirements
- R1: After `cpu_stop_n` falls, counted from the falling clock edge at which it is driven, a stoppable pair is still RUN after 4 rising clock edges and has left RUN by the 6th. The stop takes effect on the second consecutive falling-edge sample of the synchronized request.
- R2: While the stop is active, a pair with its `free_run` bit set stays in RUN (code 0).
- R3: After `cpu_stop_n` rises, a stopped pair is still stopped after 2 rising clock edges and is back in RUN by the 4th.
- R4: With both mode bits 0, a stopped pair shows code STOP6 (1) and a power-down shows code PD2 (2) on every pair.
- R5: When `stop_tristate` is 1, a stopped pair shows code HIZ (3). When either mode bit is 1, a power-down sets every pair to HIZ (3).
- R6: When power-down and stop are both active, the power-down result (R4/R5) applies to every pair.
- R7: A pair with `pair_en` 0 shows code DIS (4) whenever power-down is inactive. Stop and free-run have no effect on it.
- R8: Levels depend on the code. In RUN, true and complement are opposite and toggle every cycle. In STOP6, PD2 and DIS, true is 1 and complement is 0. In HIZ, both are 0.
- R9: A pair's code changes only on a falling edge of its true clock. A pair leaving RUN had true = 1 in the cycle before the change, and a pair entering RUN starts with true = 0.
- R10: After reset, every pair shows RUN with true 0 and complement 1.
- R11: Power-down uses the same qualification as stop. After `pwr_down_n` falls, pairs are still RUN after 4 rising edges and show the power-down code by the 6th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the CPU clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low stop request, asynchronous |
| pwr_down_n | input | 1 | Active-low power-down request, asynchronous |
| free_run | input | N_PAIRS | 1 = pair ignores the stop request |
| pair_en | input | N_PAIRS | 0 = pair disabled (DIS) |
| pd_tristate | input | 1 | Mode bit: power-down gives HIZ |
| stop_tristate | input | 1 | Mode bit: stop gives HIZ; power-down also gives HIZ |
| drive_code | output | 3*N_PAIRS | Per-pair drive code, pair i in bits [3i+2:3i] |
| clk_t | output | N_PAIRS | Gated true levels |
| clk_c | output | N_PAIRS | Gated complement levels |

## Verification
The bench builds the block with its defaults: three pairs, a two-stage synchronizer and two qualifying edges. With these values the sweep covers all 1024 combinations of the two mode bits, both requests and every free-run and enable pattern, and the truth table is checked on every pair. Two qualifying edges keep the stop and power-down latency windows a few cycles long, so the bench checks the exact earliest and latest edge of each window. A monitor watches every change of code and confirms that it falls on the falling edge of the true clock.

// File: rtl/cds_pkg.sv
package cds_pkg;
  typedef enum logic [2:0] {
    DRV_RUN   = 3'd0,
    DRV_STOP6 = 3'd1,
    DRV_PD2   = 3'd2,
    DRV_HIZ   = 3'd3,
    DRV_DIS   = 3'd4
  } drive_e;
endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_n,
  output logic q_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d_n};
  end

  assign q_n = sh_q[STAGES-1];
endmodule

// File: rtl/cds_qualify.sv
module cds_qualify #(
  parameter int QUAL_EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic req_n,
  output logic act
);
  localparam int CW = $clog2(QUAL_EDGES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_EDGES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sample) begin
      if (req_n)              cnt_d = '0;
      else if (cnt_q != QMAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign act = (cnt_d == QMAX);

  // R1 / R11: the low-sample count only moves on a falling-edge sample
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(cnt_q));
  // R3: a high sample always clears qualification
  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && req_n) |=> (cnt_q == '0));
endmodule

// File: rtl/cds_pair.sv
module cds_pair
  import cds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_evt,
  input  logic       phase,
  input  logic       stop_act,
  input  logic       pd_act,
  input  logic       fr,
  input  logic       en,
  input  logic       pd_tri,
  input  logic       stop_tri,
  output logic [2:0] code,
  output logic       t_o,
  output logic       c_o
);
  drive_e state_q, target;

  always_comb begin
    if (pd_act)                target = (pd_tri || stop_tri) ? DRV_HIZ : DRV_PD2;
    else if (!en)              target = DRV_DIS;
    else if (stop_act && !fr)  target = stop_tri ? DRV_HIZ : DRV_STOP6;
    else                       target = DRV_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= DRV_RUN;
    else if (fall_evt) state_q <= target;
  end

  always_comb begin
    unique case (state_q)
      DRV_RUN: begin t_o = phase; c_o = ~phase; end
      DRV_HIZ: begin t_o = 1'b0;  c_o = 1'b0;   end
      default: begin t_o = 1'b1;  c_o = 1'b0;   end
    endcase
  end

  assign code = state_q;

  // R9: state only changes on the true-clock falling edge
  p_change_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(state_q));
  // R8: running pairs drive opposite levels
  p_run_opposite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DRV_RUN) |-> (t_o != c_o));
  // R2: enabled free-running pair stays running outside power-down
  p_free_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !pd_act && en && fr) |=> (state_q == DRV_RUN));
  // R6: power-down wins over stop
  p_pd_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && pd_act) |=> (state_q == DRV_PD2 || state_q == DRV_HIZ));
endmodule

// File: rtl/cpu_clk_stop_ctrl.sv
module cpu_clk_stop_ctrl #(
  parameter int N_PAIRS     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_stop_n,
  input  logic                 pwr_down_n,
  input  logic [N_PAIRS-1:0]   free_run,
  input  logic [N_PAIRS-1:0]   pair_en,
  input  logic                 pd_tristate,
  input  logic                 stop_tristate,
  output logic [3*N_PAIRS-1:0] drive_code,
  output logic [N_PAIRS-1:0]   clk_t,
  output logic [N_PAIRS-1:0]   clk_c
);
  logic phase_q;
  logic stop_s_n, pd_s_n;
  logic stop_act, pd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  // the edge that moves the phase from 1 to 0 is the true clock falling edge
  logic fall_evt;
  assign fall_evt = phase_q;

  cds_sync #(.STAGES(SYNC_STAGES)) u_sync_stop (
    .clk(clk), .rst_n(rst_n), .d_n(cpu_stop_n), .q_n(stop_s_n));
  cds_sync #(.STAGES(SYNC_STAGES)) u_sync_pd (
    .clk(clk), .rst_n(rst_n), .d_n(pwr_down_n), .q_n(pd_s_n));

  cds_qualify #(.QUAL_EDGES(QUAL_EDGES)) u_qual_stop (
    .clk(clk), .rst_n(rst_n), .sample(fall_evt), .req_n(stop_s_n), .act(stop_act));
  cds_qualify #(.QUAL_EDGES(QUAL_EDGES)) u_qual_pd (
    .clk(clk), .rst_n(rst_n), .sample(fall_evt), .req_n(pd_s_n), .act(pd_act));

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    cds_pair u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (fall_evt),
      .phase    (phase_q),
      .stop_act (stop_act),
      .pd_act   (pd_act),
      .fr       (free_run[i]),
      .en       (pair_en[i]),
      .pd_tri   (pd_tristate),
      .stop_tri (stop_tristate),
      .code     (drive_code[3*i +: 3]),
      .t_o      (clk_t[i]),
      .c_o      (clk_c[i])
    );
  end

  // R1: a stop can only act after the synchronized request was low
  p_stop_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && stop_s_n) |-> !stop_act);
endmodule

// File: tb/tb_cpu_clk_stop_ctrl.sv
module tb_cpu_clk_stop_ctrl;
  localparam int N = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic stp_n = 1'b1, pd_n = 1'b1, pd_tri = 1'b0, st_tri = 1'b0;
  logic [N-1:0] fr = '0, en = '1;
  logic [3*N-1:0] code;
  logic [N-1:0] t, c;
  int checks = 0, errors = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  cpu_clk_stop_ctrl #(.N_PAIRS(N)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(stp_n), .pwr_down_n(pd_n),
    .free_run(fr), .pair_en(en), .pd_tristate(pd_tri), .stop_tristate(st_tri),
    .drive_code(code), .clk_t(t), .clk_c(c));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pc(input int i);
    return int'(code[3*i +: 3]);
  endfunction

  function automatic int exp_code(bit pdl, bit stl, bit f, bit e, bit pt, bit stt);
    if (pdl) return (pt || stt) ? 3 : 2;
    if (!e) return 4;
    if (stl && !f) return stt ? 3 : 1;
    return 0;
  endfunction

  // R9 monitor: code changes only at true-clock falling edges
  logic [2:0] prev_code [N];
  logic       prev_t [N];
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < N; i++) begin
        if (code[3*i +: 3] != prev_code[i]) begin
          if (prev_code[i] == 3'd0) chk(prev_t[i] == 1'b1, "R9 leave-run", prev_t[i], 1);
          if (code[3*i +: 3] == 3'd0) chk(t[i] == 1'b0, "R9 enter-run", t[i], 0);
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      prev_code[i] = code[3*i +: 3];
      prev_t[i]    = t[i];
    end
  end

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(pc(i) == 0, "R10 code", pc(i), 0);
      chk(t[i] == 1'b0 && c[i] == 1'b1, "R10 levels", {t[i], c[i]}, 1);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // truth-table sweep
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++)
          for (int f = 0; f < 8; f++)
            for (int e = 0; e < 8; e++) begin
              pd_tri = m[0]; st_tri = m[1]; pd_n = ~p[0]; stp_n = ~s[0];
              fr = f[N-1:0]; en = e[N-1:0];
              repeat (12) @(negedge clk);
              for (int i = 0; i < N; i++) begin
                int ex;
                string tag;
                ex = exp_code(p[0], s[0], f[i], e[i], m[0], m[1]);
                if (p[0] && s[0]) tag = "R6";
                else if (ex == 3) tag = "R5";
                else if (ex == 4) tag = "R7";
                else if (ex == 1 || ex == 2) tag = "R4";
                else if (s[0]) tag = "R2";
                else tag = "R8";
                chk(pc(i) == ex, tag, pc(i), ex);
                if (ex == 0) chk(t[i] != c[i], "R8 run opposite", {t[i], c[i]}, 1);
                else if (ex == 3) chk(!t[i] && !c[i], "R8 hiz levels", {t[i], c[i]}, 0);
                else chk(t[i] && !c[i], "R8 held levels", {t[i], c[i]}, 2);
              end
              begin
                logic [N-1:0] t0;
                t0 = t;
                @(negedge clk);
                for (int i = 0; i < N; i++)
                  if (pc(i) == 0) chk(t[i] != t0[i], "R8 toggle", t[i], ~t0[i]);
              end
            end

    // stop latency and resume
    pd_tri = 0; st_tri = 0; pd_n = 1; stp_n = 1; fr = '0; en = '1;
    repeat (10) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      stp_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(pc(0) == 0, "R1 not before 5", pc(0), 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(pc(0) == 1, "R1 by 6", pc(0), 1);
      stp_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(pc(0) == 1, "R3 not before 3", pc(0), 1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(pc(0) == 0, "R3 by 4", pc(0), 0);
      @(negedge clk);  // shift phase for second pass
    end

    // power-down latency
    for (int k = 0; k < 2; k++) begin
      pd_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(pc(1) == 0, "R11 not before 5", pc(1), 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(pc(1) == 2, "R11 by 6", pc(1), 2);
      pd_n = 1'b1;
      repeat (8) @(negedge clk);
      chk(pc(1) == 0, "R11 release", pc(1), 0);
      @(negedge clk);
    end

    // short stop glitch: a single falling-edge sample must not stop
    stp_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    stp_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(pc(2) == 0, "R1 short pulse", pc(2), 0);

    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule